// File: doc/BRIEF.md
# Token-Ordered Ring Cache Controller (MSI)

This block is the per-processor end of a snooping coherence scheme built on a one-way ring of point-to-point links. It owns a small direct-mapped cache in which each line is Invalid, Shared or Modified. It serves one load or store at a time from its processor. Every ring message that arrives is handled in one of three ways: the block forwards it, answers it by attaching its own copy of the line, or consumes it because it is one of its own messages that has come all the way round.

Ring transactions are serialized by tokens. Each token covers the line indices that are congruent to its number modulo the token count. A miss, or a store to a Shared line, may only start in the cycle the matching token arrives. The block then keeps that token until its own traffic has drained. A request travels round the ring and collects data and invalidations from the other caches on the way. When it returns, the line is installed and a writeback is sent round. When the last writeback returns, the token is put back on the ring. Tokens the block does not need are passed on after one register stage.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset the block accepts a CPU request, drives no ring message and no response, has pending count 0, holds no token, and every line is Invalid, so the first load to any address misses.
- R2: A load that hits a Shared or Modified line, or a store that hits a Modified line, completes locally. When no ring message arrives in the cycle after acceptance, the response appears one cycle later, with the line data for a load or the stored word for a store, and no ring message is produced. A local store leaves the line Modified with the new word.
- R3: A load miss waits for the token whose number (ring address field, low bits) equals line index mod NTOK, where the line index is the low log2(NLINES) address bits. In the arrival cycle of that token, with pending 0, the block takes the token and emits a Read (opcode 0) carrying the request address, its own id and data-valid 0. Pending becomes 1.
- R4: A store that misses, or that hits a Shared line, follows the same token rule and emits a Write (opcode 1).
- R5: When its own Read returns (source id equals the local id), the line is installed Shared with the returned data, the load response returns that data, and a WriteBack (opcode 2) with the address and that data is emitted one cycle later.
- R6: When its own Write returns, the line is installed Modified holding the store data, the store is acknowledged, and a WriteBack carrying the store data is emitted.
- R7: When its own WriteBack returns with pending 1, pending drops to 0 and a Token message (opcode 3) with the held token number is emitted on the next cycle. A returning own message is never forwarded.
- R8: If the install displaces a Modified line with a different tag, two WriteBacks go out: first the victim (old address, old data), then the new line at the next free output slot. Pending becomes 2. The first returning WriteBack only lowers pending to 1 and emits nothing. The second releases the token.
- R9: A Read from another cache that hits locally leaves the block with data-valid 1 and the local data attached. A Modified line drops to Shared; a Shared line stays Shared.
- R10: A Write from another cache that hits a Shared or Modified line leaves with the local data attached, and the line becomes Invalid.
- R11: Other caches' messages that miss, and all foreign WriteBacks, are forwarded unchanged one cycle after arrival, and the line state is unchanged.
- R12: A token that is not taken (wrong number, no miss waiting, or pending not 0) is forwarded unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block idle, request taken this cycle if valid |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Word address of request |
| cpu_req_data | input | DW | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_data | output | DW | Load data or echoed store data |
| ring_in_valid | input | 1 | Ring message arriving this cycle |
| ring_in_op | input | 2 | 0 Read, 1 Write, 2 WriteBack, 3 Token |
| ring_in_addr | input | AW | Line address, or token number for tokens |
| ring_in_data | input | DW | Data word |
| ring_in_dvalid | input | 1 | Data word has been supplied |
| ring_in_src | input | IDW | Originating cache id |
| ring_out_valid | output | 1 | Ring message leaving this cycle |
| ring_out_op | output | 2 | Opcode, same encoding as input |
| ring_out_addr | output | AW | Line address or token number |
| ring_out_data | output | DW | Data word |
| ring_out_dvalid | output | 1 | Data word has been supplied |
| ring_out_src | output | IDW | Originating cache id |

## Verification
The assertions assume a well-behaved ring. The block sees at most one message per cycle. A Read or Write carrying its own id returns only while it waits for one. Its own WriteBacks come back only while pending is non-zero. No two copies of a token circulate. The bench plays the rest of the ring by hand, so it keeps within these limits by construction. It sends its own messages back only after the block has emitted them, and it injects each token once per transaction. It sweeps every line index of a four-line, two-token configuration, and for each index it drives the full state path: Invalid to Shared to Modified, a downgrade, a victim eviction and an invalidation.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WBACK = 2'd2,
        OP_TOKEN = 2'd3
    } ring_op_e;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_ACT  = 2'd1,
        CS_WAIT = 2'd2
    } ctl_st_e;

    // true when the access cannot be finished from the local copy
    function automatic logic needs_ring(logic is_store, logic hit, line_st_e st);
        return !hit || (is_store && st != LN_MOD);
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_ring_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TW     = 6,
    parameter int DW     = 16,
    localparam int IW    = $clog2(NLINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_idx,
    output line_st_e      ra_st,
    output logic [TW-1:0] ra_tag,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output line_st_e      rb_st,
    output logic [TW-1:0] rb_tag,
    output logic [DW-1:0] rb_data,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  line_st_e      w_st,
    input  logic [TW-1:0] w_tag,
    input  logic [DW-1:0] w_data
);
    line_st_e      st_q   [NLINES];
    logic [TW-1:0] tag_q  [NLINES];
    logic [DW-1:0] data_q [NLINES];

    assign ra_st   = st_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign ra_data = data_q[ra_idx];
    assign rb_st   = st_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rb_data = data_q[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) st_q[i] <= LN_INV;
        end else if (we) begin
            st_q[w_idx] <= w_st;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_idx]  <= w_tag;
            data_q[w_idx] <= w_data;
        end
    end

endmodule

// File: rtl/msi_pend_track.sv
module msi_pend_track #(
    parameter int TKW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take_tok,
    input  logic [TKW-1:0] take_num,
    input  logic           set_one,
    input  logic           set_two,
    input  logic           wb_ret,
    output logic [1:0]     pending,
    output logic           tok_held,
    output logic [TKW-1:0] tok_num,
    output logic           rel_tok
);
    assign rel_tok = wb_ret && pending == 2'd1 && tok_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 2'd0;
            tok_held <= 1'b0;
            tok_num  <= '0;
        end else begin
            if (set_one)                         pending <= 2'd1;
            else if (set_two)                    pending <= 2'd2;
            else if (wb_ret && pending != 2'd0)  pending <= pending - 2'd1;
            if (take_tok) begin
                tok_held <= 1'b1;
                tok_num  <= take_num;
            end else if (rel_tok) begin
                tok_held <= 1'b0;
            end
        end
    end

    a_r7_pending_range: assert property (@(posedge clk) disable iff (rst)
        pending != 2'd3);
    a_r7_release_drains: assert property (@(posedge clk) disable iff (rst)
        rel_tok |=> pending == 2'd0 && !tok_held);
    a_r8_two_from_one: assert property (@(posedge clk) disable iff (rst)
        set_two |-> pending == 2'd1 && tok_held);
    a_r3_take_when_idle: assert property (@(posedge clk) disable iff (rst)
        take_tok |-> pending == 2'd0 && !tok_held);

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
    import msi_ring_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int NLINES   = 4,
    parameter int NTOK     = 2,
    parameter int IDW      = 3,
    parameter int CACHE_ID = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cpu_req_valid,
    output logic           cpu_req_ready,
    input  logic           cpu_req_store,
    input  logic [AW-1:0]  cpu_req_addr,
    input  logic [DW-1:0]  cpu_req_data,
    output logic           cpu_resp_valid,
    output logic [DW-1:0]  cpu_resp_data,
    input  logic           ring_in_valid,
    input  logic [1:0]     ring_in_op,
    input  logic [AW-1:0]  ring_in_addr,
    input  logic [DW-1:0]  ring_in_data,
    input  logic           ring_in_dvalid,
    input  logic [IDW-1:0] ring_in_src,
    output logic           ring_out_valid,
    output logic [1:0]     ring_out_op,
    output logic [AW-1:0]  ring_out_addr,
    output logic [DW-1:0]  ring_out_data,
    output logic           ring_out_dvalid,
    output logic [IDW-1:0] ring_out_src
);
    localparam int IW  = $clog2(NLINES);
    localparam int TW  = AW - IW;
    localparam int TKW = (NTOK > 1) ? $clog2(NTOK) : 1;
    localparam logic [IDW-1:0] MY_ID = IDW'(CACHE_ID);

    typedef struct packed {
        logic          vld;
        ring_op_e      op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          dv;
        logic [IDW-1:0] src;
    } ring_msg_t;

    typedef struct packed {
        logic          store;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cpu_req_t;

    ctl_st_e   st_q, st_d;
    cpu_req_t  cur_q;
    ring_msg_t out_q, out_d, wb2_q, wb2_d, in_m;
    logic      resp_v_d;
    logic [DW-1:0] resp_d_d;

    // line store ports
    line_st_e      c_st, s_st;
    logic [TW-1:0] c_tag, s_tag;
    logic [DW-1:0] c_data, s_data;
    logic          lw_en;
    logic [IW-1:0] lw_idx;
    line_st_e      lw_st;
    logic [TW-1:0] lw_tag;
    logic [DW-1:0] lw_data;

    // tracker ports
    logic           tk_take, pd_one, pd_two, pd_wb, tk_rel, tk_held;
    logic [1:0]     pending;
    logic [TKW-1:0] tk_num;

    assign in_m = '{vld: ring_in_valid, op: ring_op_e'(ring_in_op), addr: ring_in_addr,
                    data: ring_in_data, dv: ring_in_dvalid, src: ring_in_src};

    msi_line_store #(.NLINES(NLINES), .TW(TW), .DW(DW)) u_lines (
        .clk(clk), .rst(rst),
        .ra_idx(cur_q.addr[IW-1:0]), .ra_st(c_st), .ra_tag(c_tag), .ra_data(c_data),
        .rb_idx(ring_in_addr[IW-1:0]), .rb_st(s_st), .rb_tag(s_tag), .rb_data(s_data),
        .we(lw_en), .w_idx(lw_idx), .w_st(lw_st), .w_tag(lw_tag), .w_data(lw_data)
    );

    msi_pend_track #(.TKW(TKW)) u_track (
        .clk(clk), .rst(rst),
        .take_tok(tk_take), .take_num(ring_in_addr[TKW-1:0]),
        .set_one(pd_one), .set_two(pd_two), .wb_ret(pd_wb),
        .pending(pending), .tok_held(tk_held), .tok_num(tk_num), .rel_tok(tk_rel)
    );

    logic           cur_hit, cur_need, snp_hit, in_own, victim;
    logic [TKW-1:0] cur_cls;
    logic [DW-1:0]  new_data;

    assign cur_hit  = c_st != LN_INV && c_tag == cur_q.addr[AW-1:IW];
    assign cur_need = needs_ring(cur_q.store, cur_hit, c_st);
    assign cur_cls  = TKW'(32'(cur_q.addr[IW-1:0]) % NTOK);
    assign snp_hit  = s_st != LN_INV && s_tag == ring_in_addr[AW-1:IW];
    assign in_own   = ring_in_src == MY_ID;
    assign victim   = c_st == LN_MOD && c_tag != cur_q.addr[AW-1:IW];
    assign new_data = cur_q.store ? cur_q.data : ring_in_data;

    always_comb begin
        st_d     = st_q;
        out_d    = '0;
        wb2_d    = wb2_q;
        resp_v_d = 1'b0;
        resp_d_d = '0;
        lw_en    = 1'b0;
        lw_idx   = ring_in_addr[IW-1:0];
        lw_st    = LN_INV;
        lw_tag   = s_tag;
        lw_data  = s_data;
        tk_take  = 1'b0;
        pd_one   = 1'b0;
        pd_two   = 1'b0;
        pd_wb    = 1'b0;
        if (ring_in_valid) begin
            if (in_m.op == OP_TOKEN) begin
                if (st_q == CS_ACT && cur_need && pending == 2'd0 && !tk_held
                    && ring_in_addr[TKW-1:0] == cur_cls) begin
                    tk_take = 1'b1;
                    pd_one  = 1'b1;
                    st_d    = CS_WAIT;
                    out_d   = '{vld: 1'b1, op: cur_q.store ? OP_WRITE : OP_READ,
                                addr: cur_q.addr, data: cur_q.data, dv: 1'b0, src: MY_ID};
                end else begin
                    out_d = in_m;
                end
            end else if (in_own) begin
                if (in_m.op == OP_WBACK) begin
                    pd_wb = 1'b1;
                    if (tk_rel)
                        out_d = '{vld: 1'b1, op: OP_TOKEN, addr: AW'(tk_num),
                                  data: '0, dv: 1'b0, src: MY_ID};
                end else if (st_q == CS_WAIT) begin
                    lw_en    = 1'b1;
                    lw_idx   = cur_q.addr[IW-1:0];
                    lw_st    = cur_q.store ? LN_MOD : LN_SHR;
                    lw_tag   = cur_q.addr[AW-1:IW];
                    lw_data  = new_data;
                    resp_v_d = 1'b1;
                    resp_d_d = new_data;
                    st_d     = CS_IDLE;
                    if (victim) begin
                        pd_two = 1'b1;
                        out_d  = '{vld: 1'b1, op: OP_WBACK, addr: {c_tag, cur_q.addr[IW-1:0]},
                                   data: c_data, dv: 1'b1, src: MY_ID};
                        wb2_d  = '{vld: 1'b1, op: OP_WBACK, addr: cur_q.addr,
                                   data: new_data, dv: 1'b1, src: MY_ID};
                    end else begin
                        out_d  = '{vld: 1'b1, op: OP_WBACK, addr: cur_q.addr,
                                   data: new_data, dv: 1'b1, src: MY_ID};
                    end
                end
            end else begin
                out_d = in_m;
                if (snp_hit && in_m.op != OP_WBACK) begin
                    out_d.data = s_data;
                    out_d.dv   = 1'b1;
                    if (in_m.op == OP_WRITE || s_st == LN_MOD) begin
                        lw_en = 1'b1;
                        lw_st = (in_m.op == OP_WRITE) ? LN_INV : LN_SHR;
                    end
                end
            end
        end else if (st_q == CS_ACT && !cur_need) begin
            resp_v_d = 1'b1;
            resp_d_d = cur_q.store ? cur_q.data : c_data;
            st_d     = CS_IDLE;
            if (cur_q.store) begin
                lw_en   = 1'b1;
                lw_idx  = cur_q.addr[IW-1:0];
                lw_st   = LN_MOD;
                lw_tag  = c_tag;
                lw_data = cur_q.data;
            end
        end
        // deferred second writeback takes any free output slot
        if (wb2_q.vld && !out_d.vld) begin
            out_d = wb2_q;
            wb2_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= CS_IDLE;
            cur_q          <= '0;
            out_q          <= '0;
            wb2_q          <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_data  <= '0;
        end else begin
            st_q           <= st_d;
            out_q          <= out_d;
            wb2_q          <= wb2_d;
            cpu_resp_valid <= resp_v_d;
            cpu_resp_data  <= resp_d_d;
            if (cpu_req_valid && st_q == CS_IDLE) begin
                cur_q <= '{store: cpu_req_store, addr: cpu_req_addr, data: cpu_req_data};
                st_q  <= CS_ACT;
            end
        end
    end

    assign cpu_req_ready   = st_q == CS_IDLE;
    assign ring_out_valid  = out_q.vld;
    assign ring_out_op     = out_q.op;
    assign ring_out_addr   = out_q.addr;
    assign ring_out_data   = out_q.data;
    assign ring_out_dvalid = out_q.dv;
    assign ring_out_src    = out_q.src;

    a_r11_foreign_passes: assert property (@(posedge clk) disable iff (rst)
        ring_in_valid && ring_in_op != 2'd3 && ring_in_src != MY_ID
        |=> ring_out_valid && ring_out_op == $past(ring_in_op)
            && ring_out_addr == $past(ring_in_addr) && ring_out_src == $past(ring_in_src));
    a_r3_issue_needs_token: assert property (@(posedge clk) disable iff (rst)
        ring_out_valid && ring_out_op inside {2'd0, 2'd1} && ring_out_src == MY_ID
        |-> tk_held);
    a_r5_return_answers: assert property (@(posedge clk) disable iff (rst)
        ring_in_valid && ring_in_op inside {2'd0, 2'd1} && ring_in_src == MY_ID && st_q == CS_WAIT
        |=> ring_out_valid && ring_out_op == 2'd2 && cpu_resp_valid);
    a_r7_token_back: assert property (@(posedge clk) disable iff (rst)
        ring_in_valid && ring_in_op == 2'd2 && ring_in_src == MY_ID && pending == 2'd1
        |=> ring_out_valid && ring_out_op == 2'd3);
    a_r12_token_forward: assert property (@(posedge clk) disable iff (rst)
        ring_in_valid && ring_in_op == 2'd3 && st_q != CS_ACT
        |=> ring_out_valid && ring_out_op == 2'd3 && ring_out_addr == $past(ring_in_addr));
    a_r2_resp_after_accept: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> cpu_req_ready && $past(st_q != CS_IDLE));

endmodule

// File: tb/msi_ring_ctrl_bench.sv
module msi_ring_ctrl_bench;
    localparam int AW = 8, DW = 16, IDW = 3, MYID = 3, NTOK = 2;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2, TK = 2'd3;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req_valid = 0, cpu_req_store = 0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_data = '0;
    logic cpu_req_ready, cpu_resp_valid;
    logic [DW-1:0] cpu_resp_data;
    logic ring_in_valid = 0, ring_in_dvalid = 0;
    logic [1:0] ring_in_op = '0;
    logic [AW-1:0] ring_in_addr = '0;
    logic [DW-1:0] ring_in_data = '0;
    logic [IDW-1:0] ring_in_src = '0;
    logic ring_out_valid, ring_out_dvalid;
    logic [1:0] ring_out_op;
    logic [AW-1:0] ring_out_addr;
    logic [DW-1:0] ring_out_data;
    logic [IDW-1:0] ring_out_src;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    msi_ring_ctrl #(.AW(AW), .DW(DW), .NLINES(4), .NTOK(NTOK), .IDW(IDW), .CACHE_ID(MYID)) u_msi_ring_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_store(cpu_req_store), .cpu_req_addr(cpu_req_addr), .cpu_req_data(cpu_req_data),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_data(cpu_resp_data),
        .ring_in_valid(ring_in_valid), .ring_in_op(ring_in_op), .ring_in_addr(ring_in_addr),
        .ring_in_data(ring_in_data), .ring_in_dvalid(ring_in_dvalid), .ring_in_src(ring_in_src),
        .ring_out_valid(ring_out_valid), .ring_out_op(ring_out_op), .ring_out_addr(ring_out_addr),
        .ring_out_data(ring_out_data), .ring_out_dvalid(ring_out_dvalid), .ring_out_src(ring_out_src)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ring_send(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic dv, logic [IDW-1:0] s);
        ring_in_valid = 1; ring_in_op = op; ring_in_addr = a;
        ring_in_data = d; ring_in_dvalid = dv; ring_in_src = s;
        tick();
        ring_in_valid = 0;
    endtask

    task automatic cpu(logic st, logic [AW-1:0] a, logic [DW-1:0] d);
        chk("R2", "ready before request", 32'(cpu_req_ready), 1);
        cpu_req_valid = 1; cpu_req_store = st; cpu_req_addr = a; cpu_req_data = d;
        tick();
        cpu_req_valid = 0;
    endtask

    task automatic exp_out(string req, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                           logic dv, logic [IDW-1:0] s, bit cmp_data);
        chk(req, "out valid", 32'(ring_out_valid), 1);
        chk(req, "out op", 32'(ring_out_op), 32'(op));
        chk(req, "out addr", 32'(ring_out_addr), 32'(a));
        chk(req, "out src", 32'(ring_out_src), 32'(s));
        if (cmp_data) begin
            chk(req, "out data", 32'(ring_out_data), 32'(d));
            chk(req, "out dvalid", 32'(ring_out_dvalid), 32'(dv));
        end
    endtask

    // full transaction after the request was accepted and is known to miss
    task automatic miss_flow(string req, logic st, logic [AW-1:0] a, logic [DW-1:0] sd, logic [DW-1:0] rd);
        logic [TKW_B-1:0] cls;
        cls = a[0];
        tick();
        chk(req, "no local completion", 32'(cpu_resp_valid), 0);
        chk(req, "no ring traffic while waiting", 32'(ring_out_valid), 0);
        ring_send(TK, AW'(cls ^ 1'b1), '0, 0, 3'd0);
        exp_out("R12", TK, AW'(cls ^ 1'b1), '0, 0, 3'd0, 0);
        ring_send(TK, AW'(cls), '0, 0, 3'd0);
        exp_out(st ? "R4" : "R3", st ? WR : RD, a, '0, 0, 3'(MYID), 0);
        chk(st ? "R4" : "R3", "out dvalid", 32'(ring_out_dvalid), 0);
        ring_send(st ? WR : RD, a, rd, 1, 3'(MYID));
        chk(st ? "R6" : "R5", "resp valid", 32'(cpu_resp_valid), 1);
        chk(st ? "R6" : "R5", "resp data", 32'(cpu_resp_data), 32'(st ? sd : rd));
        exp_out(st ? "R6" : "R5", WB, a, st ? sd : rd, 1, 3'(MYID), 1);
        ring_send(WB, a, st ? sd : rd, 1, 3'(MYID));
        exp_out("R7", TK, AW'(cls), '0, 0, 3'(MYID), 0);
        tick();
        chk("R7", "token not repeated", 32'(ring_out_valid), 0);
    endtask
    localparam int TKW_B = 1;

    task automatic local_hit(string req, logic st, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] exp);
        cpu(st, a, d);
        tick();
        chk(req, "local resp valid", 32'(cpu_resp_valid), 1);
        chk(req, "local resp data", 32'(cpu_resp_data), 32'(exp));
        chk(req, "no ring traffic", 32'(ring_out_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(cpu_req_ready), 1);
        chk("R1", "no ring out after reset", 32'(ring_out_valid), 0);
        chk("R1", "no resp after reset", 32'(cpu_resp_valid), 0);
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] a, b, o;
            logic [DW-1:0] d1, d2, d3, d4, d5;
            a = {6'd1, 2'(i)}; b = {6'd2, 2'(i)}; o = {6'd3, 2'(i)};
            d1 = 16'h1100 + 16'(i); d2 = 16'h2200 + 16'(i); d3 = 16'h3300 + 16'(i);
            d4 = 16'h4400 + 16'(i); d5 = 16'h5500 + 16'(i);
            // R1: cold line misses, then load fill
            cpu(0, a, '0);
            miss_flow("R1", 0, a, '0, d1);
            local_hit("R2", 0, a, '0, d1);
            // R9 shared hit answered, state kept
            ring_send(RD, a, 16'hDEAD, 0, 3'd1);
            exp_out("R9", RD, a, d1, 1, 3'd1, 1);
            // R11 foreign writeback and foreign miss pass unchanged
            ring_send(WB, a, 16'h5555, 1, 3'd2);
            exp_out("R11", WB, a, 16'h5555, 1, 3'd2, 1);
            ring_send(RD, o, 16'hBEEF, 0, 3'd6);
            exp_out("R11", RD, o, 16'hBEEF, 0, 3'd6, 1);
            local_hit("R11", 0, a, '0, d1);
            // R4 store to shared line upgrades via ring
            cpu(1, a, d2);
            miss_flow("R4", 1, a, d2, 16'hEE00 + 16'(i));
            local_hit("R2", 1, a, d3, d3);
            local_hit("R2", 0, a, '0, d3);
            // R9 modified hit downgraded
            ring_send(RD, a, 16'h0, 0, 3'd5);
            exp_out("R9", RD, a, d3, 1, 3'd5, 1);
            cpu(1, a, d4);
            miss_flow("R9", 1, a, d4, 16'h0);
            // R8 victim eviction of modified line
            cpu(1, b, d5);
            tick();
            chk("R8", "miss no resp", 32'(cpu_resp_valid), 0);
            ring_send(TK, AW'(i % NTOK), '0, 0, 3'd0);
            exp_out("R8", WR, b, '0, 0, 3'(MYID), 0);
            ring_send(WR, b, 16'h0, 0, 3'(MYID));
            chk("R8", "resp data", 32'(cpu_resp_data), 32'(d5));
            exp_out("R8", WB, a, d4, 1, 3'(MYID), 1);
            tick();
            exp_out("R8", WB, b, d5, 1, 3'(MYID), 1);
            ring_send(WB, a, d4, 1, 3'(MYID));
            chk("R8", "first return holds token", 32'(ring_out_valid), 0);
            ring_send(WB, b, d5, 1, 3'(MYID));
            exp_out("R8", TK, AW'(i % NTOK), '0, 0, 3'(MYID), 0);
            // R10 foreign write invalidates modified line
            ring_send(WR, b, 16'h0, 0, 3'd4);
            exp_out("R10", WR, b, d5, 1, 3'd4, 1);
            cpu(0, b, '0);
            miss_flow("R10", 0, b, '0, 16'h7700 + 16'(i));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule